// File: doc/BRIEF.md
# Acquire-Time Deferred Invalidation Tracker

This block sits beside a node's cache controller in a multiprocessor that keeps coherence under a lazy release model. Write notices from other nodes do not invalidate local lines when they arrive. The tracker only records that a cached line is stale. The invalidations are carried out later, when the local processor acquires a lock. It also follows fills and evictions of local lines. A line that leaves the cache therefore carries no stale record, and every line that leaves, whether by eviction or by invalidation, is reported to its home node's directory as dropped.

An acquire is handled in two passes. On the acquire-start pulse, the tracker freezes the set of lines that are stale at that moment. It invalidates that set one line per cycle, lowest line number first, while the lock request is still outstanding. When the lock-grant pulse arrives, a second pass clears every stale mark that is still left, including marks from notices that arrived during the wait. When no marks remain, the tracker pulses acquire-done for one cycle. Each invalidation drives an invalidate command to the cache tags and a drop message to the home node. An eviction uses the same drop channel, tagged as an eviction.

Top module: `acq_inval_tracker`

## Requirements
- R1: A notice for a cached line only marks that line. No invalidation is issued outside an acquire, and during an acquire only marked lines are invalidated.
- R2: A notice for a line that is not cached is ignored. It leads to no invalidation in any later acquire.
- R3: An eviction clears any mark on that line. In the next cycle it drives `drop_vld` with `drop_evict`=1 and `drop_line` equal to the evicted line. A fill also clears any mark on the filled line.
- R4: An acquire-start in the idle state fixes the set of lines marked before that cycle. While the grant is pending, that set is invalidated one line per cycle, lowest line number first. Marks that arrive later wait for the second pass.
- R5: Once the grant is seen, all remaining marks are invalidated lowest line number first. After a cycle in this pass with no marks, `acq_done` is high for exactly one cycle, and the tracker returns to idle. A start and a grant in the same idle cycle go straight to this pass.
- R6: A line chosen in cycle t appears in cycle t+1 as `inv_vld` with `inv_line`. In the same cycle it appears as `drop_vld` with `drop_evict`=0 and the same `drop_line`.
- R7: In a cycle with an eviction, no invalidation is chosen, so the eviction has the drop channel to itself.
- R8: A notice for a line in the same cycle that the line is chosen for invalidation leaves the line marked. It is invalidated again in the second pass.
- R9: An acquire-start while an acquire is in progress is ignored, and so is a grant while idle.
- R10: After reset, no line is cached or marked and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| notice_vld | input | 1 | Write notice arrives |
| notice_line | input | LW | Line index named by the notice |
| fill_vld | input | 1 | Line filled into the local cache |
| fill_line | input | LW | Filled line index |
| evict_vld | input | 1 | Line evicted for capacity or conflict |
| evict_line | input | LW | Evicted line index |
| acq_start | input | 1 | Lock acquire begins (pulse) |
| lock_grant | input | 1 | Lock ownership granted (pulse) |
| inv_vld | output | 1 | Invalidate command to cache tags |
| inv_line | output | LW | Line to invalidate |
| drop_vld | output | 1 | Drop message to the home node |
| drop_line | output | LW | Line no longer cached |
| drop_evict | output | 1 | 1: drop caused by an eviction, 0: by an invalidation |
| acq_done | output | 1 | Acquire may complete (one-cycle pulse) |

## Verification
The assertions assume well-formed cache events. An eviction names a line that is cached, a fill names a line that is not cached, and a fill and an eviction never name the same line in one cycle. The random phase of the stimulus picks eviction targets and fill targets from the bench's own view of which lines are cached, so it never breaks these rules. Notices, acquire-starts and grants are not restricted, so the stimulus also covers notices for uncached lines, starts that arrive in the middle of an acquire, and grants that arrive while idle.

// File: rtl/ait_pkg.sv
package ait_pkg;
  typedef enum logic [1:0] {
    AQ_IDLE  = 2'd0,
    AQ_WAIT  = 2'd1,
    AQ_DRAIN = 2'd2
  } aq_state_e;
endpackage

// File: rtl/ait_line_state.sv
module ait_line_state #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 notice_vld,
  input  logic [LW-1:0]        notice_line,
  input  logic                 fill_vld,
  input  logic [LW-1:0]        fill_line,
  input  logic                 evict_vld,
  input  logic [LW-1:0]        evict_line,
  input  logic                 capture,
  input  logic                 inv_fire,
  input  logic [LW-1:0]        inv_sel,
  output logic [NUM_LINES-1:0] mark_q,
  output logic [NUM_LINES-1:0] snap_q
);
  logic [NUM_LINES-1:0] cached_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [LW-1:0] IDX = LW'(g);
    logic hit_n, hit_f, hit_e, hit_i, en;
    logic c_d, m_d, s_d;
    logic c_q, m_q, s_q;

    always_comb begin
      hit_n = notice_vld && (notice_line == IDX) && c_q;
      hit_f = fill_vld   && (fill_line   == IDX);
      hit_e = evict_vld  && (evict_line  == IDX);
      hit_i = inv_fire   && (inv_sel     == IDX);
      en    = hit_n | hit_f | hit_e | hit_i | capture;

      c_d = c_q;
      if (hit_e)      c_d = 1'b0;
      else if (hit_f) c_d = 1'b1;
      else if (hit_i) c_d = 1'b0;

      m_d = m_q;
      if (hit_e || hit_f) m_d = 1'b0;
      else if (hit_n)     m_d = 1'b1;
      else if (hit_i)     m_d = 1'b0;

      if (capture) s_d = m_q & m_d;
      else         s_d = s_q & m_d & ~hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= 1'b0;
        m_q <= 1'b0;
        s_q <= 1'b0;
      end else if (en) begin
        c_q <= c_d;
        m_q <= m_d;
        s_q <= s_d;
      end
    end

    assign cached_q[g] = c_q;
    assign mark_q[g]   = m_q;
    assign snap_q[g]   = s_q;
  end
endmodule

// File: rtl/ait_prio_pick.sv
module ait_prio_pick #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] cand,
  output logic                 any,
  output logic [LW-1:0]        idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/ait_ctrl.sv
module ait_ctrl
  import ait_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_start,
  input  logic                 lock_grant,
  input  logic                 evict_vld,
  input  logic [LW-1:0]        evict_line,
  input  logic [NUM_LINES-1:0] mark_q,
  input  logic [NUM_LINES-1:0] snap_q,
  input  logic                 pick_any,
  input  logic [LW-1:0]        pick_idx,
  output logic [NUM_LINES-1:0] cand,
  output logic                 capture,
  output logic                 inv_fire,
  output logic                 busy,
  output logic                 inv_vld,
  output logic [LW-1:0]        inv_line,
  output logic                 drop_vld,
  output logic [LW-1:0]        drop_line,
  output logic                 drop_evict,
  output logic                 acq_done
);
  aq_state_e   state_q, state_d;
  logic        done_d, drop_d;
  logic [LW-1:0] drop_line_d;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    done_d  = 1'b0;
    cand    = '0;
    unique case (state_q)
      AQ_IDLE: begin
        if (acq_start) begin
          capture = 1'b1;
          state_d = lock_grant ? AQ_DRAIN : AQ_WAIT;
        end
      end
      AQ_WAIT: begin
        cand = mark_q & snap_q;
        if (lock_grant) state_d = AQ_DRAIN;
      end
      AQ_DRAIN: begin
        cand = mark_q;
        if (mark_q == '0) begin
          state_d = AQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = AQ_IDLE;
    endcase
  end

  always_comb begin
    inv_fire    = pick_any && !evict_vld;
    drop_d      = inv_fire || evict_vld;
    drop_line_d = evict_vld ? evict_line : pick_idx;
  end

  assign busy = (state_q != AQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= AQ_IDLE;
      acq_done   <= 1'b0;
      inv_vld    <= 1'b0;
      inv_line   <= '0;
      drop_vld   <= 1'b0;
      drop_line  <= '0;
      drop_evict <= 1'b0;
    end else begin
      state_q    <= state_d;
      acq_done   <= done_d;
      inv_vld    <= inv_fire;
      drop_vld   <= drop_d;
      drop_evict <= evict_vld;
      if (inv_fire) inv_line  <= pick_idx;
      if (drop_d)   drop_line <= drop_line_d;
    end
  end
endmodule

// File: rtl/acq_inval_tracker.sv
module acq_inval_tracker #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          notice_vld,
  input  logic [LW-1:0] notice_line,
  input  logic          fill_vld,
  input  logic [LW-1:0] fill_line,
  input  logic          evict_vld,
  input  logic [LW-1:0] evict_line,
  input  logic          acq_start,
  input  logic          lock_grant,
  output logic          inv_vld,
  output logic [LW-1:0] inv_line,
  output logic          drop_vld,
  output logic [LW-1:0] drop_line,
  output logic          drop_evict,
  output logic          acq_done
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic [NUM_LINES-1:0] mark_q, snap_q, cand;
  logic                 capture, inv_fire, busy, pick_any;
  logic [LW-1:0]        pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  ait_line_state #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_core_n),
    .notice_vld(notice_vld), .notice_line(notice_line),
    .fill_vld(fill_vld), .fill_line(fill_line),
    .evict_vld(evict_vld), .evict_line(evict_line),
    .capture(capture), .inv_fire(inv_fire), .inv_sel(pick_idx),
    .mark_q(mark_q), .snap_q(snap_q)
  );

  ait_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .cand(cand), .any(pick_any), .idx(pick_idx)
  );

  ait_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .acq_start(acq_start), .lock_grant(lock_grant),
    .evict_vld(evict_vld), .evict_line(evict_line),
    .mark_q(mark_q), .snap_q(snap_q),
    .pick_any(pick_any), .pick_idx(pick_idx),
    .cand(cand), .capture(capture), .inv_fire(inv_fire), .busy(busy),
    .inv_vld(inv_vld), .inv_line(inv_line),
    .drop_vld(drop_vld), .drop_line(drop_line), .drop_evict(drop_evict),
    .acq_done(acq_done)
  );
endmodule

// File: rtl/ait_checker.sv
module ait_checker #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evict_vld,
  input logic [LW-1:0]        evict_line,
  input logic                 inv_vld,
  input logic [LW-1:0]        inv_line,
  input logic                 drop_vld,
  input logic [LW-1:0]        drop_line,
  input logic                 drop_evict,
  input logic                 acq_done,
  input logic                 busy,
  input logic [NUM_LINES-1:0] mark_q,
  input logic [NUM_LINES-1:0] snap_q
);
  a_r6_inv_pairs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> (drop_vld && !drop_evict && drop_line == inv_line));

  a_r3_evict_drop: assert property (@(posedge clk) disable iff (!rst_n)
    evict_vld |=> (drop_vld && drop_evict && drop_line == $past(evict_line)));

  a_r7_evict_stalls_inv: assert property (@(posedge clk) disable iff (!rst_n)
    evict_vld |=> !inv_vld);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done);

  a_r5_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> ($past(mark_q) == '0));

  a_r1_no_inv_idle: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> $past(busy));

  a_r4_snap_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q & ~mark_q) == '0);
endmodule

bind acq_inval_tracker ait_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .evict_vld(evict_vld), .evict_line(evict_line),
  .inv_vld(inv_vld), .inv_line(inv_line),
  .drop_vld(drop_vld), .drop_line(drop_line), .drop_evict(drop_evict),
  .acq_done(acq_done), .busy(busy),
  .mark_q(mark_q), .snap_q(snap_q)
);

// File: tb/acq_inval_tracker_bench.sv
`timescale 1ns/1ps
module acq_inval_tracker_bench;
  localparam int NL = 16;
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic notice_vld = 1'b0, fill_vld = 1'b0, evict_vld = 1'b0;
  logic [LW-1:0] notice_line = '0, fill_line = '0, evict_line = '0;
  logic acq_start = 1'b0, lock_grant = 1'b0;
  logic inv_vld, drop_vld, drop_evict, acq_done;
  logic [LW-1:0] inv_line, drop_line;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit m_mark[NL];
  bit m_cach[NL];
  bit m_snap[NL];
  int m_st = 0; // 0 idle, 1 waiting for grant, 2 after grant

  always #2.5 clk = ~clk;

  acq_inval_tracker #(.NUM_LINES(NL)) u_acq_inval_tracker (
    .clk(clk), .rst_n(rst_n),
    .notice_vld(notice_vld), .notice_line(notice_line),
    .fill_vld(fill_vld), .fill_line(fill_line),
    .evict_vld(evict_vld), .evict_line(evict_line),
    .acq_start(acq_start), .lock_grant(lock_grant),
    .inv_vld(inv_vld), .inv_line(inv_line),
    .drop_vld(drop_vld), .drop_line(drop_line), .drop_evict(drop_evict),
    .acq_done(acq_done)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit nv, input int nl, input bit fv, input int fl,
                      input bit ev, input int el, input bit as, input bit gr);
    bit om[NL]; bit oc[NL]; bit os[NL];
    bit found, issue, e_inv, e_drop, e_ev, e_done, empty;
    int pick, e_dl;
    notice_vld = nv; notice_line = LW'(nl);
    fill_vld = fv;   fill_line = LW'(fl);
    evict_vld = ev;  evict_line = LW'(el);
    acq_start = as;  lock_grant = gr;
    @(posedge clk);
    #1;
    notice_vld = 0; fill_vld = 0; evict_vld = 0; acq_start = 0; lock_grant = 0;
    om = m_mark; oc = m_cach; os = m_snap;
    found = 0; pick = 0; empty = 1;
    for (int i = 0; i < NL; i++) if (om[i]) empty = 0;
    if (m_st != 0) begin
      for (int i = NL - 1; i >= 0; i--) begin
        if (om[i] && (m_st == 2 || os[i])) begin found = 1; pick = i; end
      end
    end
    issue  = found && !ev;
    e_inv  = issue;
    e_drop = issue || ev;
    e_ev   = ev;
    e_dl   = ev ? el : pick;
    e_done = (m_st == 2) && empty;
    for (int i = 0; i < NL; i++) begin
      bit hn, hf, he, hi;
      hn = nv && nl == i && oc[i];
      hf = fv && fl == i;
      he = ev && el == i;
      hi = issue && pick == i;
      if (he) m_cach[i] = 0; else if (hf) m_cach[i] = 1; else if (hi) m_cach[i] = 0;
      if (he || hf) m_mark[i] = 0; else if (hn) m_mark[i] = 1; else if (hi) m_mark[i] = 0;
      if (m_st == 0 && as) m_snap[i] = om[i] && m_mark[i];
      else m_snap[i] = os[i] && m_mark[i] && !hi;
    end
    case (m_st)
      0: if (as) m_st = gr ? 2 : 1;
      1: if (gr) m_st = 2;
      default: if (empty) m_st = 0;
    endcase
    check(tag,
          inv_vld == e_inv && (!e_inv || inv_line == LW'(pick)) &&
          drop_vld == e_drop && (!e_drop || (drop_line == LW'(e_dl) && drop_evict == e_ev)) &&
          acq_done == e_done,
          $sformatf("inv=%0b/%0d drop=%0b/%0d ev=%0b done=%0b",
                    inv_vld, inv_line, drop_vld, drop_line, drop_evict, acq_done),
          $sformatf("inv=%0b/%0d drop=%0b/%0d ev=%0b done=%0b",
                    e_inv, pick, e_drop, e_dl, e_ev, e_done));
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int dones;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", {inv_vld, drop_vld, drop_evict, acq_done} == 4'b0,
          $sformatf("%b", {inv_vld, drop_vld, drop_evict, acq_done}), "0000");
    idle("R10", 2);

    // fill lines 3,5,9,12,14
    step("R10", 0, 0, 1, 3, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 5, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 9, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 12, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 14, 0, 0, 0, 0);
    // R1: notices only mark
    step("R1", 1, 5, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 9, 0, 0, 0, 0, 0, 0);
    // R2: notice on uncached line 7
    step("R2", 1, 7, 0, 0, 0, 0, 0, 0);
    // R3: mark 12, evict 12, refill 12
    step("R3", 1, 12, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 1, 12, 0, 0);
    step("R3", 0, 0, 1, 12, 0, 0, 0, 0);
    idle("R1", 3);
    // R4: first pass on 5 then 9
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R4", 1);
    // R8: notice on 9 in the cycle 9 is picked
    step("R8", 1, 9, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 3, 0, 0, 0, 0, 0, 0);
    idle("R4", 3);
    // R9: second start ignored
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R9", 2);
    // R5: grant, then R7 eviction stall
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 1, 14, 0, 0);
    idle("R5", 5);
    // R9: grant while idle ignored
    dones = 0;
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
      if (acq_done) dones++;
    end
    check("R9", dones == 0, $sformatf("%0d", dones), "0");
    // R5: start and grant together, no marks
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1);
    idle("R5", 3);
    // R2: line 7 never invalidated in a new acquire
    step("R2", 1, 7, 0, 0, 0, 0, 1, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R2", 4);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit nv, fv, ev, as, gr;
      int nl, fl, el;
      nv = ($urandom % 3) == 0; nl = $urandom % NL;
      fv = 0; fl = 0; ev = 0; el = 0;
      if (($urandom % 5) == 0) begin
        int s = $urandom % NL;
        for (int j = 0; j < NL; j++) if (!fv && !m_cach[(s + j) % NL]) begin fv = 1; fl = (s + j) % NL; end
      end
      if (($urandom % 6) == 0) begin
        int s = $urandom % NL;
        for (int j = 0; j < NL; j++)
          if (!ev && m_cach[(s + j) % NL] && !(fv && fl == (s + j) % NL)) begin ev = 1; el = (s + j) % NL; end
      end
      as = ($urandom % 25) == 0;
      gr = ($urandom % 15) == 0;
      step("R5", nv, nl, fv, fl, ev, el, as, gr);
    end
    finish_run();
  end
endmodule